// File: doc/BRIEF.md
# Parallel Flash Command Sequencer with Completion Polling

This block sits on the host side of an 8-bit parallel flash bus. A user request carries an operation code, a target address, a data byte and a choice of polling method. For each request the block runs one operation from start to finish: a byte program, a whole-chip erase, or an identification read. It first issues the unlock write cycles at the fixed command addresses. For program and erase it then keeps reading the device until the device reports that its internal operation has finished. It signals `done` once, with `err` set if the device stayed busy too long.

All bus timing is counted in system clocks. The write-pulse width, write recovery gap, output-enable-to-data delay and output-enable high time come from nanosecond parameters and the clock period. Each rounds up to the smallest whole number of cycles that meets the minimum. The flash array, and the electrical tri-state detail of the data pins, are outside the block: the data bus is exposed as separate out, in and drive-enable lines.

Polling has two methods. In bit-7 mode the block reads the target address until bit 7 equals the true bit 7 of the written data. For erase, that true bit is 1. In toggle mode it compares bit 6 of two reads in a row at the target address and stops when the two are equal.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, chip enable, output enable and write enable are all high (inactive), the data drive `f_dq_oe` is low, and `done` is low.
- R2: Operation code 0 (program) produces exactly four writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then `req_data` to `req_addr`.
- R3: Operation code 1 (erase) produces exactly six writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x10 to 0x5555.
- R4: Each write holds write enable low for exactly `ceil(WP_NS*1000/CLK_PS)` cycles, which is 12 at the defaults. Between writes, write enable stays high for at least `ceil(WPH_NS*1000/CLK_PS)` cycles (12). Address and data do not change while write enable is low. `f_dq_oe` is high exactly when write enable is low. Chip enable is low whenever either strobe is low.
- R5: Output enable and write enable are never low in the same cycle. Each read holds output enable low for exactly `ceil(OED_NS*1000/CLK_PS)` cycles (5), and the byte is taken at the end of that window.
- R6: Between two reads, output enable stays high for at least `ceil(OEH_NS*1000/CLK_PS)` cycles (19).
- R7: With `req_toggle`=0, polling reads `req_addr`. It finishes on the first read whose bit 7 equals bit 7 of `req_data` for program, or 1 for erase. `rd_data` then holds that read.
- R8: With `req_toggle`=1, polling reads `req_addr`. It finishes on the first read whose bit 6 equals bit 6 of the read just before it.
- R9: If polling has not finished when its cycle count reaches `PROG_TMO` (program) or `ERASE_TMO` (erase), the block stops at the next read and raises `err` together with `done`. Otherwise `err` is low at `done`.
- R10: Operation code 2 (ID read) writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0x90 to 0x5555. It then reads `req_addr` once and writes 0xF0 to 0x5555. `rd_data` holds the byte that was read.
- R11: A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `done` is high for exactly one cycle per request and `req_ready` returns the next cycle. `req_valid` raised while busy causes no bus cycle and no extra `done`.
- R12: Operation code 3 performs no bus cycle and completes with `done` and `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 program, 1 erase, 2 ID read, 3 no operation |
| req_toggle | input | 1 | Polling method: 0 bit 7, 1 bit-6 toggle |
| req_addr | input | 16 | Target address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout flag, valid at done |
| rd_data | output | 8 | Last byte read from the device |
| f_addr | output | 16 | Flash address bus |
| f_dq_out | output | 8 | Flash data to drive |
| f_dq_oe | output | 1 | Drive enable for f_dq_out |
| f_dq_in | input | 8 | Flash data read back |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench models the device behaviourally. After the last command write it answers a chosen number of busy reads with inverted bit 7 and an alternating bit 6, then returns the true byte. Program and erase each run under both polling methods, with busy counts and data bytes picked so that the expected read counts differ. A block that applied the wrong bit, the wrong comparison or an off-by-one stop would therefore fail. ID reads at two addresses check that the response byte is captured at the end of the read window. Timeout runs with a device that never finishes separate the program limit from the erase limit. A request held high during an operation, and the no-operation code, show that no stray bus cycles appear.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_ERASE = 2'd1, OP_ID = 2'd2, OP_NONE = 2'd3} op_e;
  typedef enum logic [1:0] {K_WR, K_RD, K_POLL, K_END} kind_e;

  typedef struct packed {
    kind_e         kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } step_t;

  // smallest whole cycle count covering a nanosecond minimum, never zero
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // three-cycle unlock pattern; the third write carries the command byte
  function automatic step_t unlock(logic [1:0] j, logic [DW-1:0] cmd);
    step_t s;
    s.kind = K_WR;
    case (j)
      2'd0:    begin s.addr = AW'(16'h5555); s.data = 8'hAA; end
      2'd1:    begin s.addr = AW'(16'h2AAA); s.data = 8'h55; end
      default: begin s.addr = AW'(16'h5555); s.data = cmd;   end
    endcase
    return s;
  endfunction

  function automatic step_t cmd_step(op_e op, logic [2:0] idx, logic [AW-1:0] a, logic [DW-1:0] d);
    step_t s;
    s.kind = K_END; s.addr = '0; s.data = '0;
    case (op)
      OP_PROG: begin
        if (idx < 3'd3)       s = unlock(idx[1:0], 8'hA0);
        else if (idx == 3'd3) begin s.kind = K_WR; s.addr = a; s.data = d; end
        else if (idx == 3'd4) s.kind = K_POLL;
      end
      OP_ERASE: begin
        if (idx < 3'd3)       s = unlock(idx[1:0], 8'h80);
        else if (idx < 3'd6)  s = unlock(2'(idx - 3'd3), 8'h10);
        else if (idx == 3'd6) s.kind = K_POLL;
      end
      OP_ID: begin
        if (idx < 3'd3)       s = unlock(idx[1:0], 8'h90);
        else if (idx == 3'd3) begin s.kind = K_RD; s.addr = a; end
        else if (idx == 3'd4) begin s.kind = K_WR; s.addr = AW'(16'h5555); s.data = 8'hF0; end
      end
      default: s.kind = K_END;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fpc_bus_cycle.sv
module fpc_bus_cycle
  import fpc_pkg::*;
#(
  parameter int unsigned WR_LO = 12,
  parameter int unsigned WR_HI = 12,
  parameter int unsigned RD_LO = 5,
  parameter int unsigned RD_HI = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] dq_in,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_dq_out,
  output logic          f_dq_oe,
  output logic          f_oe_n,
  output logic          f_we_n
);
  localparam int unsigned CMAX = max2(max2(WR_LO, WR_HI), max2(RD_LO, RD_HI));
  localparam int unsigned CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_e;
  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          is_wr;
  logic          ph_last;

  assign ph_last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; is_wr <= 1'b0;
      f_addr <= '0; f_dq_out <= '0; rdata <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph       <= PH_LO;
          is_wr    <= wr;
          f_addr   <= addr_i;
          f_dq_out <= data_i;
          cnt      <= wr ? CW'(WR_LO - 1) : CW'(RD_LO - 1);
        end
        PH_LO: if (ph_last) begin
          ph  <= PH_HI;
          cnt <= is_wr ? CW'(WR_HI - 1) : CW'(RD_HI - 1);
          if (!is_wr) rdata <= dq_in;
        end else cnt <= cnt - 1'b1;
        default: if (ph_last) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign fin     = (ph == PH_HI) && ph_last;
  assign f_we_n  = !((ph == PH_LO) && is_wr);
  assign f_oe_n  = !((ph == PH_LO) && !is_wr);
  assign f_dq_oe = (ph == PH_LO) && is_wr;

  // run-length watchers for the strobe assertions
  logic [CW:0] we_lo_run, oe_hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_run <= '0;
      oe_hi_run <= (CW+1)'(RD_HI);
    end else begin
      we_lo_run <= f_we_n ? '0 : we_lo_run + 1'b1;
      if (!f_oe_n) oe_hi_run <= '0;
      else if (oe_hi_run < (CW+1)'(RD_HI)) oe_hi_run <= oe_hi_run + 1'b1;
    end
  end

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!f_we_n && !f_oe_n));
  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n) |-> (we_lo_run == (CW+1)'(WR_LO)));
  a_r6_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_oe_n) |-> (oe_hi_run >= (CW+1)'(RD_HI)));
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(f_dq_out)));
endmodule

// File: rtl/fpc_poll_eval.sv
module fpc_poll_eval
  import fpc_pkg::*;
(
  input  logic          use_toggle,
  input  logic [DW-1:0] rdata,
  input  logic          exp7,
  input  logic          prev_ok,
  input  logic          prev6,
  output logic          complete
);
  logic bit7_hit, tog_hit;
  assign bit7_hit = (rdata[7] == exp7);
  assign tog_hit  = prev_ok && (rdata[6] == prev6);
  assign complete = use_toggle ? tog_hit : bit7_hit;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned CLK_PS    = 8000,
  parameter int unsigned WP_NS     = 90,
  parameter int unsigned WPH_NS    = 90,
  parameter int unsigned OEH_NS    = 150,
  parameter int unsigned OED_NS    = 40,
  parameter int unsigned PROG_TMO  = 2000,
  parameter int unsigned ERASE_TMO = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_toggle,
  input  logic [15:0]   req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          err,
  output logic [7:0]    rd_data,
  output logic [15:0]   f_addr,
  output logic [7:0]    f_dq_out,
  output logic          f_dq_oe,
  input  logic [7:0]    f_dq_in,
  output logic          f_ce_n,
  output logic          f_oe_n,
  output logic          f_we_n
);
  localparam int unsigned WP_C  = ns_to_cyc(WP_NS, CLK_PS);
  localparam int unsigned WPH_C = ns_to_cyc(WPH_NS, CLK_PS);
  localparam int unsigned OEH_C = ns_to_cyc(OEH_NS, CLK_PS);
  localparam int unsigned OED_C = ns_to_cyc(OED_NS, CLK_PS);
  localparam int unsigned TW    = $clog2(max2(PROG_TMO, ERASE_TMO) + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_POLL, S_END} st_e;
  st_e           st;
  op_e           op_q;
  logic          tog_q, inflight, have_prev, prev6, err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q, bus_rdata;
  logic [2:0]    idx;
  logic [TW-1:0] tmo_cnt, tmo_lim;
  step_t         cur;

  // named internal events
  logic bus_step, start, fin, bus_busy, rd_fin, poll_hit, timed_out, exp7, poll_fin;

  assign cur       = cmd_step(op_q, idx, addr_q, data_q);
  assign bus_step  = (cur.kind == K_WR) || (cur.kind == K_RD);
  assign start     = !inflight && !bus_busy && (((st == S_RUN) && bus_step) || (st == S_POLL));
  assign rd_fin    = fin && ((st == S_POLL) || ((st == S_RUN) && (cur.kind == K_RD)));
  assign poll_fin  = fin && (st == S_POLL);
  assign exp7      = (op_q == OP_ERASE) ? 1'b1 : data_q[7];
  assign tmo_lim   = (op_q == OP_ERASE) ? TW'(ERASE_TMO) : TW'(PROG_TMO);
  assign timed_out = (tmo_cnt >= tmo_lim);

  fpc_bus_cycle #(.WR_LO(WP_C), .WR_HI(WPH_C), .RD_LO(OED_C), .RD_HI(OEH_C)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wr((st == S_RUN) && (cur.kind == K_WR)),
    .addr_i((st == S_RUN) ? cur.addr : addr_q), .data_i(cur.data),
    .dq_in(f_dq_in), .busy(bus_busy), .fin(fin), .rdata(bus_rdata),
    .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe),
    .f_oe_n(f_oe_n), .f_we_n(f_we_n)
  );

  fpc_poll_eval u_eval (
    .use_toggle(tog_q), .rdata(bus_rdata), .exp7(exp7),
    .prev_ok(have_prev), .prev6(prev6), .complete(poll_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_NONE; tog_q <= 1'b0; addr_q <= '0; data_q <= '0;
      idx <= '0; inflight <= 1'b0; have_prev <= 1'b0; prev6 <= 1'b0;
      err_q <= 1'b0; rd_q <= '0; tmo_cnt <= '0;
    end else begin
      if (start)  inflight <= 1'b1;
      if (fin)    inflight <= 1'b0;
      if (rd_fin) rd_q <= bus_rdata;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= op_e'(req_op); tog_q <= req_toggle;
          addr_q <= req_addr; data_q <= req_data;
          idx <= '0; err_q <= 1'b0; have_prev <= 1'b0; tmo_cnt <= '0;
          st <= S_RUN;
        end
        S_RUN: begin
          if (cur.kind == K_POLL)     st <= S_POLL;
          else if (cur.kind == K_END) st <= S_END;
          else if (fin)               idx <= idx + 1'b1;
        end
        S_POLL: begin
          if (!timed_out) tmo_cnt <= tmo_cnt + 1'b1;
          if (poll_fin) begin
            have_prev <= 1'b1;
            prev6     <= bus_rdata[6];
            if (poll_hit) st <= S_END;
            else if (timed_out) begin err_q <= 1'b1; st <= S_END; end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_END);
  assign err       = err_q;
  assign rd_data   = rd_q;
  assign f_ce_n    = (st == S_IDLE);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (f_ce_n && f_we_n && f_oe_n && !f_dq_oe && !done));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  a_r9_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (done && $past(timed_out)));
  a_r7_hit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_fin && poll_hit) |=> (done && !err));
  a_r4_ce_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_we_n || !f_oe_n) |-> !f_ce_n);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_toggle, done, err, f_dq_oe, f_ce_n, f_oe_n, f_we_n;
  logic [1:0] req_op;
  logic [15:0] req_addr, f_addr;
  logic [7:0] req_data, rd_data, f_dq_out, f_dq_in, resp;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_toggle(req_toggle), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .rd_data(rd_data), .f_addr(f_addr), .f_dq_out(f_dq_out),
    .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in), .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle minimums restated as "first n with n*8ns >= limit"
  function automatic int min_cycles(input int ns);
    int n = 1;
    while (n * 8 < ns) n++;
    return n;
  endfunction
  int WP_C, WPH_C, OEH_C, RD_C;

  // expected poll read count from the device model's answer sequence
  function automatic int exp_reads(input bit tg, input int b, input logic [7:0] r);
    logic [7:0] prev, s;
    logic t;
    prev = '0;
    t = ~r[6];
    for (int k = 0; k < 100000; k++) begin
      if (k < b) begin s = {~r[7], t, r[5:0]}; t = ~t; end
      else s = r;
      if (!tg && s[7] == r[7]) return k + 1;
      if (tg && k > 0 && s[6] == prev[6]) return k + 1;
      prev = s;
    end
    return -1;
  endfunction

  typedef struct { logic [15:0] a; logic [7:0] d; } wr_t;
  wr_t exp_wr[$];
  wr_t ew;
  string wr_tag = "R2";
  int busy_left = 0, arm_busy = 0, rd_seen = 0, done_cnt = 0;
  bit arm_pend = 0, id_mode = 0, idle_m = 0, done_prev = 0;
  logic tog_b = 1'b0;
  logic [7:0] real_b = 8'hFF;
  logic [15:0] poll_addr = '0, ca = '0;
  logic [7:0] cd = '0;
  bit prev_we = 1, prev_oe = 1;
  int we_lo = 0, we_hi = 1000, oe_lo = 0, oe_hi = 1000;
  longint cyc = 0, last_rise = 0, done_cyc = 0;

  assign f_dq_in = f_oe_n ? 8'h00 : resp;
  always @(posedge clk) cyc++;

  // behavioural device and bus monitor, sampled at the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!f_we_n && !f_oe_n) chk(0, "R5 oe and we both low", 0, 1);
      if ((!f_we_n || !f_oe_n) && f_ce_n) chk(0, "R4 ce high during strobe", 1, 0);
      if (f_dq_oe != !f_we_n) chk(0, "R4 data drive outside write", f_dq_oe, !f_we_n);
      if (done_prev) idle_m = 1;
      if (idle_m) chk(req_ready && f_ce_n && f_we_n && f_oe_n && !done, "R11 idle compare",
                      {req_ready, f_ce_n, f_we_n, f_oe_n, done}, 5'b11110);
      // write strobe
      if (!f_we_n) begin
        if (prev_we) begin
          if (we_hi < WPH_C) chk(0, "R4 write gap", we_hi, WPH_C);
          we_lo = 0; ca = f_addr; cd = f_dq_out;
        end else if (f_addr != ca || f_dq_out != cd) chk(0, "R4 addr/data moved", {f_addr, f_dq_out}, {ca, cd});
        we_lo++;
      end else begin
        if (!prev_we) begin
          chk(we_lo == WP_C, "R4 write low width", we_lo, WP_C);
          if (exp_wr.size() == 0) chk(0, "R11 unexpected write", {ca, cd}, 0);
          else begin
            ew = exp_wr.pop_front();
            chk(ew.a == ca && ew.d == cd, wr_tag, {ca, cd}, {ew.a, ew.d});
          end
          if (exp_wr.size() == 0 && arm_pend) begin
            arm_pend = 0; busy_left = arm_busy; tog_b = ~real_b[6];
          end
          last_rise = cyc; we_hi = 0;
        end
        we_hi++;
      end
      prev_we = f_we_n;
      // read strobe
      if (!f_oe_n) begin
        if (prev_oe) begin
          if (oe_hi < OEH_C) chk(0, "R6 read gap", oe_hi, OEH_C);
          oe_lo = 0; rd_seen++;
          if (f_addr != poll_addr) chk(0, "R7 read address", f_addr, poll_addr);
          if (id_mode) resp = f_addr[0] ? 8'h03 : 8'h1F;
          else if (busy_left > 0) begin
            resp = {~real_b[7], tog_b, real_b[5:0]}; tog_b = ~tog_b; busy_left--;
          end else resp = real_b;
        end
        oe_lo++;
      end else begin
        if (!prev_oe) begin chk(oe_lo == RD_C, "R5 read low width", oe_lo, RD_C); oe_hi = 0; end
        oe_hi++;
      end
      prev_oe = f_oe_n;
      if (done) begin done_cnt++; done_cyc = cyc; end
      done_prev = done;
    end
  end

  task automatic push_wr(input logic [15:0] a, input logic [7:0] d);
    wr_t w; w.a = a; w.d = d; exp_wr.push_back(w);
  endtask

  task automatic push_unlock(input logic [7:0] cmd);
    push_wr(16'h5555, 8'hAA); push_wr(16'h2AAA, 8'h55); push_wr(16'h5555, cmd);
  endtask

  task automatic run_op(input logic [1:0] op, input bit tg, input logic [15:0] a,
                        input logic [7:0] d, input int busy, input bit exp_to);
    int dn0, nr;
    string rq;
    exp_wr.delete();
    id_mode = (op == 2'd2); poll_addr = a; rd_seen = 0; arm_busy = busy;
    real_b = (op == 2'd1) ? 8'hFF : d;
    arm_pend = (op == 2'd0 || op == 2'd1);
    case (op)
      2'd0: begin wr_tag = "R2 program write"; push_unlock(8'hA0); push_wr(a, d); end
      2'd1: begin wr_tag = "R3 erase write"; push_unlock(8'h80); push_unlock(8'h10); end
      2'd2: begin wr_tag = "R10 id write"; push_unlock(8'h90); push_wr(16'h5555, 8'hF0); end
      default: wr_tag = "R12 stray write";
    endcase
    @(posedge clk); #1;
    req_op = op; req_toggle = tg; req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; idle_m = 0;
    dn0 = done_cnt;
    while (done_cnt == dn0) @(negedge clk);
    chk(exp_wr.size() == 0, (op == 2'd1) ? "R3 all writes seen" : "R2 all writes seen", exp_wr.size(), 0);
    rq = tg ? "R8 toggle poll" : "R7 bit7 poll";
    if (op == 2'd3) begin
      chk(!err && rd_seen == 0, "R12 no-op", {err, 8'(rd_seen)}, 0);
    end else if (op == 2'd2) begin
      chk(rd_seen == 1 && rd_data == (a[0] ? 8'h03 : 8'h1F), "R10 id byte", rd_data, a[0] ? 8'h03 : 8'h1F);
    end else if (exp_to) begin
      chk(err == 1'b1, "R9 timeout flag", err, 1);
      chk(done_cyc - last_rise >= ((op == 2'd1) ? 20000 : 2000) &&
          done_cyc - last_rise <= ((op == 2'd1) ? 20000 : 2000) + WPH_C + RD_C + OEH_C + 10,
          "R9 timeout window", done_cyc - last_rise, (op == 2'd1) ? 20000 : 2000);
    end else begin
      nr = exp_reads(tg, busy, real_b);
      chk(err == 1'b0, "R9 no error on success", err, 0);
      chk(rd_seen == nr, rq, rd_seen, nr);
      chk(rd_data == real_b, "R7 final byte", rd_data, real_b);
    end
  endtask

  initial begin
    WP_C = min_cycles(90); WPH_C = min_cycles(90); OEH_C = min_cycles(150); RD_C = min_cycles(40);
    resp = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_toggle = 1'b0; req_addr = '0; req_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && f_ce_n && f_we_n && f_oe_n && !f_dq_oe && !done, "R1 reset state",
        {req_ready, f_ce_n, f_we_n, f_oe_n, f_dq_oe, done}, 6'b111100);
    idle_m = 1;

    run_op(2'd0, 1'b0, 16'h3456, 8'h5A, 3, 1'b0);   // program, bit-7 poll
    run_op(2'd0, 1'b1, 16'h7001, 8'h5A, 4, 1'b0);   // program, toggle poll
    run_op(2'd0, 1'b0, 16'h0010, 8'hC3, 0, 1'b0);   // program, device already done
    run_op(2'd1, 1'b0, 16'h0000, 8'h00, 2, 1'b0);   // erase, bit-7 poll
    run_op(2'd1, 1'b1, 16'h1234, 8'h00, 5, 1'b0);   // erase, toggle poll
    run_op(2'd2, 1'b0, 16'h0000, 8'h00, 0, 1'b0);   // id read, maker byte
    run_op(2'd2, 1'b0, 16'h0001, 8'h00, 0, 1'b0);   // id read, device byte
    run_op(2'd3, 1'b0, 16'h0000, 8'h00, 0, 1'b0);   // no-op code

    // R11: request raised while busy is ignored
    begin
      int d0;
      d0 = done_cnt;
      fork
        run_op(2'd0, 1'b0, 16'h4444, 8'h12, 3, 1'b0);
        begin
          repeat (30) @(posedge clk); #1;
          req_op = 2'd1; req_valid = 1'b1;
          repeat (20) @(posedge clk); #1;
          req_valid = 1'b0;
        end
      join
      repeat (300) @(negedge clk);
      chk(done_cnt == d0 + 1 && req_ready, "R11 busy request ignored", done_cnt - d0, 1);
    end

    run_op(2'd0, 1'b1, 16'h2222, 8'h77, 1000000, 1'b1);  // program timeout
    run_op(2'd1, 1'b0, 16'h0000, 8'h00, 1000000, 1'b1);  // erase timeout

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule